// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block runs one general-purpose I/O port of `WIDTH` pins, eight by default. Each pin's mode is set by six bus-visible registers: an output data latch, a read-only sampled-input view, a direction mask, a pull-device request mask, a low-strength drive mask and an open-drain (wired-or) mask. A peripheral module can claim any pin through a per-pin override. While it holds the pin, the peripheral supplies the pin's output value and output enable, and the port's own direction setting is ignored.

Pin inputs pass through a multi-flop synchronizer before they reach any read path. The data address reads back per bit: it returns the stored latch bit for pins set as outputs and the sampled pin for pins set as inputs. The block turns the pull request off whenever the pad is actively driving. A register write lands on the next rising clock edge. A read is combinational in the same cycle.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every register reads 0, and `pin_oe`, `pin_out`, `pull_en` and `pin_weak` are all 0.
- R2: A value on `pin_in` shows in the input register (address 1) exactly `SYNC_STAGES` rising edges after it is applied, and not one edge earlier.
- R3: A read of address 0 returns the stored data bit for each pin whose direction bit is 1 and the synchronized pin for each pin whose direction bit is 0.
- R4: Address 1 always returns the synchronized pins, whatever the direction and override settings. Writes to address 1 change no register.
- R5: A pin with no override, direction 1 and wired-or bit 0 drives `pin_oe`=1 and `pin_out` equal to its data bit.
- R6: A pin with no override and direction 0 has `pin_oe`=0 and `pin_out`=0, so writes to the data register have no effect on it.
- R7: A pin with no override, direction 1 and wired-or bit 1 has `pin_out`=0 and `pin_oe` equal to the inverse of its data bit.
- R8: A pin with `periph_en` set takes `pin_out` from `periph_out` and `pin_oe` from `periph_oe`. Its direction bit is ignored.
- R9: `pull_en` is set for a pin only when its pull register bit (address 3) is 1 and that pin's `pin_oe` is 0.
- R10: `pin_weak` always equals the reduced-drive register (address 4).
- R11: Addresses 2, 3, 4 and 5 (direction, pull, reduced drive, wired-or) read back the last value written. Addresses 6 and 7 read 0. `bus_rdata` is 0 unless a read is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data, combinational |
| pin_in | input | WIDTH | Raw pad input levels |
| periph_en | input | WIDTH | Per-pin peripheral override |
| periph_out | input | WIDTH | Peripheral output value |
| periph_oe | input | WIDTH | Peripheral output enable |
| pin_out | output | WIDTH | Pad output value |
| pin_oe | output | WIDTH | Pad output enable |
| pull_en | output | WIDTH | Pull-device enable |
| pin_weak | output | WIDTH | Reduced drive strength select |

## Verification
The bench builds the port with its defaults: eight pins, a three-bit address and a two-stage synchronizer. With these values, per-pin mixes of input, push-pull, open-drain and overridden pins can all be set up in one pattern. Every address is reachable, including the two unmapped ones. The two-edge input latency can be probed on both sides of its boundary.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   localparam int unsigned ADR_DATA = 0;
   localparam int unsigned ADR_INPUT = 1;
   localparam int unsigned ADR_DIR = 2;
   localparam int unsigned ADR_PULL = 3;
   localparam int unsigned ADR_WEAK = 4;
   localparam int unsigned ADR_OPEN = 5;
   localparam int unsigned NUM_ADDR = 6;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= din;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
      end
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_port_pkg::*;
#(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WIDTH-1:0]  wdata,
   input  logic [WIDTH-1:0]  pins_sync,
   output logic [WIDTH-1:0]  rdata,
   output logic [WIDTH-1:0]  data_q,
   output logic [WIDTH-1:0]  dir_q,
   output logic [WIDTH-1:0]  pull_q,
   output logic [WIDTH-1:0]  weak_q,
   output logic [WIDTH-1:0]  open_q
);
   logic wr_go;
   assign wr_go = sel & wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         dir_q  <= '0;
         pull_q <= '0;
         weak_q <= '0;
         open_q <= '0;
      end else if (wr_go) begin
         case (int'(addr))
            ADR_DATA: data_q <= wdata;
            ADR_DIR:  dir_q  <= wdata;
            ADR_PULL: pull_q <= wdata;
            ADR_WEAK: weak_q <= wdata;
            ADR_OPEN: open_q <= wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      rdata = '0;
      if (sel && !wr) begin
         case (int'(addr))
            ADR_DATA:  rdata = (data_q & dir_q) | (pins_sync & ~dir_q);
            ADR_INPUT: rdata = pins_sync;
            ADR_DIR:   rdata = dir_q;
            ADR_PULL:  rdata = pull_q;
            ADR_WEAK:  rdata = weak_q;
            ADR_OPEN:  rdata = open_q;
            default:   rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive (
   input  logic ovr_en,
   input  logic ovr_out,
   input  logic ovr_oe,
   input  logic dir,
   input  logic data,
   input  logic open_drain,
   input  logic pull_req,
   output logic out,
   output logic oe,
   output logic pull_on
);
   always_comb begin
      if (ovr_en) begin
         out = ovr_out;
         oe  = ovr_oe;
      end else if (!dir) begin
         out = 1'b0;
         oe  = 1'b0;
      end else if (open_drain) begin
         out = 1'b0;
         oe  = ~data;
      end else begin
         out = data;
         oe  = 1'b1;
      end
   end

   assign pull_on = pull_req & ~oe;
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
   import gpio_port_pkg::*;
#(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   input  logic [WIDTH-1:0]  pin_in,
   input  logic [WIDTH-1:0]  periph_en,
   input  logic [WIDTH-1:0]  periph_out,
   input  logic [WIDTH-1:0]  periph_oe,
   output logic [WIDTH-1:0]  pin_out,
   output logic [WIDTH-1:0]  pin_oe,
   output logic [WIDTH-1:0]  pull_en,
   output logic [WIDTH-1:0]  pin_weak
);
   localparam int unsigned ADDR_SPAN = 1 << ADDR_W;

   if (WIDTH < 1 || WIDTH > 64) begin : g_bad_width
      $error("gpio_port_ctrl: WIDTH must be 1..64");
   end
   if (ADDR_SPAN < NUM_ADDR) begin : g_bad_addr
      $error("gpio_port_ctrl: ADDR_W too small for register map");
   end
   if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("gpio_port_ctrl: SYNC_STAGES must be 2..4");
   end

   logic [WIDTH-1:0] pins_sync;
   logic [WIDTH-1:0] data_q, dir_q, pull_q, weak_q, open_q;

   gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pin_in),
      .dout (pins_sync)
   );

   gpio_port_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (bus_sel),
      .wr       (bus_wr),
      .addr     (bus_addr),
      .wdata    (bus_wdata),
      .pins_sync(pins_sync),
      .rdata    (bus_rdata),
      .data_q   (data_q),
      .dir_q    (dir_q),
      .pull_q   (pull_q),
      .weak_q   (weak_q),
      .open_q   (open_q)
   );

   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      gpio_pin_drive u_drv (
         .ovr_en    (periph_en[i]),
         .ovr_out   (periph_out[i]),
         .ovr_oe    (periph_oe[i]),
         .dir       (dir_q[i]),
         .data      (data_q[i]),
         .open_drain(open_q[i]),
         .pull_req  (pull_q[i]),
         .out       (pin_out[i]),
         .oe        (pin_oe[i]),
         .pull_on   (pull_en[i])
      );
   end

   assign pin_weak = weak_q;
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk
   import gpio_port_pkg::*;
#(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [WIDTH-1:0]  bus_rdata,
   input logic [WIDTH-1:0]  pin_in,
   input logic [WIDTH-1:0]  periph_en,
   input logic [WIDTH-1:0]  periph_out,
   input logic [WIDTH-1:0]  periph_oe,
   input logic [WIDTH-1:0]  pin_out,
   input logic [WIDTH-1:0]  pin_oe,
   input logic [WIDTH-1:0]  pull_en,
   input logic [WIDTH-1:0]  pin_weak,
   input logic [WIDTH-1:0]  data_q,
   input logic [WIDTH-1:0]  dir_q,
   input logic [WIDTH-1:0]  pull_q,
   input logic [WIDTH-1:0]  weak_q,
   input logic [WIDTH-1:0]  open_q
);
   logic [1:0] age;
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)          age <= '0;
      else if (age != 2'd3) age <= age + 2'd1;

   logic [WIDTH-1:0] pp_m, in_m, od_m;
   assign pp_m = ~periph_en & dir_q & ~open_q;
   assign in_m = ~periph_en & ~dir_q;
   assign od_m = ~periph_en & dir_q & open_q;

   logic rd_input, wr_input;
   assign rd_input = bus_sel && !bus_wr && (int'(bus_addr) == ADR_INPUT);
   assign wr_input = bus_sel && bus_wr && (int'(bus_addr) == ADR_INPUT);

   // R2
   sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_input && age >= 2'd2) |-> (bus_rdata == $past(pin_in, 2)));

   // R4
   input_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_input |=> $stable({data_q, dir_q, pull_q, weak_q, open_q}));

   // R5
   push_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pp_m & (~pin_oe | (pin_out ^ data_q))) == '0);

   // R6
   gp_input_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_m & (pin_oe | pin_out)) == '0);

   // R7
   open_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (od_m & (pin_out | ~(pin_oe ^ data_q))) == '0);

   // R8
   override_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (periph_en & ((pin_out ^ periph_out) | (pin_oe ^ periph_oe))) == '0);

   // R9
   pull_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pull_en & (pin_oe | ~pull_q)) == '0);

   // R10
   weak_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pin_weak == weak_q);
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .pin_in    (pin_in),
   .periph_en (periph_en),
   .periph_out(periph_out),
   .periph_oe (periph_oe),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .pull_en   (pull_en),
   .pin_weak  (pin_weak),
   .data_q    (data_q),
   .dir_q     (dir_q),
   .pull_q    (pull_q),
   .weak_q    (weak_q),
   .open_q    (open_q)
);

// File: tb/gpio_port_ctrl_tb.sv
module gpio_port_ctrl_tb;
   localparam int CLK_P = 10;
   localparam int W = 8;
   localparam int AW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [W-1:0]  bus_wdata = '0;
   logic [W-1:0]  bus_rdata;
   logic [W-1:0]  pin_in = '0;
   logic [W-1:0]  periph_en = '0;
   logic [W-1:0]  periph_out = '0;
   logic [W-1:0]  periph_oe = '0;
   logic [W-1:0]  pin_out, pin_oe, pull_en, pin_weak;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_P/2) clk = ~clk;

   gpio_port_ctrl #(.WIDTH(W), .ADDR_W(AW), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .periph_en(periph_en), .periph_out(periph_out),
      .periph_oe(periph_oe), .pin_out(pin_out), .pin_oe(pin_oe),
      .pull_en(pull_en), .pin_weak(pin_weak)
   );

   task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input int a, input logic [W-1:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [W-1:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = AW'(a);
      #1;
      d = bus_rdata;
      bus_sel = 1'b0;
      #1;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [W-1:0] v;
      for (int a = 0; a < 8; a++) begin
         rd(a, v);
         chk("R1 reg read", v, '0);
      end
      chk("R1 pin_oe", pin_oe, '0);
      chk("R1 pin_out", pin_out, '0);
      chk("R1 pull_en", pull_en, '0);
      chk("R1 pin_weak", pin_weak, '0);
   endtask

   task automatic t_sync;
      logic [W-1:0] v;
      @(negedge clk);
      pin_in = 8'hA5;
      @(negedge clk);
      rd(1, v);
      chk("R2 one edge", v, 8'h00);
      @(negedge clk);
      rd(1, v);
      chk("R2 two edges", v, 8'hA5);
   endtask

   task automatic t_readback;
      logic [W-1:0] v;
      pin_in = 8'h0F;
      idle(3);
      wr(0, 8'h3C);
      wr(2, 8'hF0);
      rd(0, v); chk("R3 mixed dir", v, 8'h3F);
      wr(2, 8'h00);
      rd(0, v); chk("R3 all input", v, 8'h0F);
      wr(2, 8'hFF);
      rd(0, v); chk("R3 all output", v, 8'h3C);
   endtask

   task automatic t_input_reg;
      logic [W-1:0] v;
      periph_en = 8'hFF;
      rd(1, v); chk("R4 input w/ override", v, 8'h0F);
      wr(1, 8'hFF);
      rd(2, v); chk("R4 dir after input write", v, 8'hFF);
      rd(0, v); chk("R4 data after input write", v, 8'h3C);
      rd(1, v); chk("R4 input after write", v, 8'h0F);
      periph_en = 8'h00;
   endtask

   task automatic t_drive;
      wr(2, 8'h0F);
      wr(0, 8'h96);
      wr(5, 8'h00);
      #1;
      chk("R5 pp oe", pin_oe, 8'h0F);
      chk("R5 R6 out", pin_out, 8'h06);
      wr(2, 8'h00);
      wr(0, 8'hFF);
      #1;
      chk("R6 input oe", pin_oe, 8'h00);
      chk("R6 input out", pin_out, 8'h00);
   endtask

   task automatic t_open_drain;
      wr(2, 8'hFF);
      wr(5, 8'hF0);
      wr(0, 8'h5A);
      #1;
      chk("R7 oe", pin_oe, 8'hAF);
      chk("R7 out", pin_out, 8'h0A);
   endtask

   task automatic t_periph;
      periph_en = 8'hC3; periph_out = 8'h81; periph_oe = 8'h41;
      #1;
      chk("R8 oe", pin_oe, 8'h6D);
      chk("R8 out", pin_out, 8'h89);
   endtask

   task automatic t_pull;
      wr(3, 8'hFF);
      #1;
      chk("R9 mixed", pull_en, 8'h92);
      periph_en = 8'h00;
      wr(2, 8'h00);
      #1;
      chk("R9 inputs", pull_en, 8'hFF);
      wr(2, 8'hFF);
      wr(5, 8'h00);
      #1;
      chk("R9 push-pull", pull_en, 8'h00);
   endtask

   task automatic t_misc;
      logic [W-1:0] v;
      wr(4, 8'h33);
      #1;
      chk("R10 pin_weak", pin_weak, 8'h33);
      rd(4, v); chk("R11 weak read", v, 8'h33);
      rd(3, v); chk("R11 pull read", v, 8'hFF);
      rd(2, v); chk("R11 dir read", v, 8'hFF);
      wr(5, 8'h6C);
      rd(5, v); chk("R11 open read", v, 8'h6C);
      rd(6, v); chk("R11 addr6", v, 8'h00);
      rd(7, v); chk("R11 addr7", v, 8'h00);
      bus_addr = 3'd2; #1;
      chk("R11 no select", bus_rdata, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_sync;
      t_readback;
      t_input_reg;
      t_drive;
      t_open_drain;
      t_periph;
      t_pull;
      t_misc;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_P * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule